// File: doc/BRIEF.md
# Four-Thread Instruction Issue Selector

This block sits between a prefetch engine and a single in-order execution pipeline that four hardware threads share. Each thread owns a small instruction queue. The prefetcher loads the queue through a push port and watches a full flag. The pipeline receives at most one instruction per cycle, tagged with the number of the thread it belongs to, so that later stages can steer it to that thread's own register state.

Selection is event driven, not time sliced. A thread stays eligible only while its queue holds an instruction, its stall input is low and it is not being flushed. Each cycle the selector scans the threads in rotating order, starting just after the thread it last issued from, and takes the first eligible one. When nothing is eligible, the valid output stays low for that cycle. A per-thread flush discards everything queued for that thread.

Top module: `thread_issue_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `iss_valid` is low and every `pf_full` bit is low (all queues empty).
- R2: Instructions of one thread leave on `iss_instr` in the order they were pushed; a push becomes visible for issue on the cycle after its clock edge.
- R3: `pf_full[t]` is high exactly when queue t holds 4 entries; a push to a full queue is dropped, even when that queue also issues in the same cycle.
- R4: A thread whose `stall` bit is high in a cycle is never selected in that cycle.
- R5: A thread whose queue is empty is never selected.
- R6: Among eligible threads, the selected one is the first found when scanning upward (with wrap-around) from the thread after the last one that issued; after reset the scan starts at thread 0.
- R7: When no thread is eligible, `iss_valid` is low; when at least one is, `iss_valid` is high.
- R8: Every issued instruction carries the number of its thread on `iss_tid`, and issuing removes that instruction from the thread's queue.
- R9: `flush[t]` empties queue t at the clock edge, drops a push to t in the same cycle, and excludes t from selection in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_push | input | NUM_THR | Per-thread push strobe from the prefetcher |
| pf_data | input | NUM_THR*INSTR_W | Per-thread instruction word, thread t in bits [t*INSTR_W +: INSTR_W] |
| pf_full | output | NUM_THR | Per-thread queue full flag |
| stall | input | NUM_THR | Per-thread stall, applies to the same cycle's selection |
| flush | input | NUM_THR | Per-thread queue flush |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_tid | output | $clog2(NUM_THR) | Thread number of the issued instruction |
| iss_instr | output | INSTR_W | Issued instruction word |

## Verification
On every cycle the assertions check that an issued thread is neither stalled nor empty, that valid matches the presence of an eligible thread, that the grant is one-hot, that queue occupancy never exceeds the depth, and that a flush leaves its queue empty. Rotating fairness, the pushed order of instruction words and the exact cycles at which dropped pushes show up can only be seen against the bench's behavioural model of queues and last-issued pointer, run through directed scenarios and a long stretch of random push, stall and flush traffic.

// File: rtl/thrd_sel_pkg.sv
package thrd_sel_pkg;

   // Index reached by stepping `step` positions forward from `base` in a ring of `n`.
   function automatic int ring_step(input int base, input int step, input int n);
      return (base + step) % n;
   endfunction

   // Bits needed to hold values 0..n-1, never below one.
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/thr_fifo.sv
module thr_fifo
   import thrd_sel_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   input  logic             flush,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int AW = idx_bits(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("thr_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("thr_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)) else $error("queue occupancy above depth"); // R3
   AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (full && $stable(head))) else $error("push into full queue altered it"); // R3
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty) else $error("queue not empty after flush"); // R9
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty) else $error("pop from empty queue"); // R5
endmodule

// File: rtl/rr_pick.sv
module rr_pick
   import thrd_sel_pkg::*;
#(
   parameter int N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic [idx_bits(N)-1:0] last,
   output logic [N-1:0]         gnt,
   output logic [idx_bits(N)-1:0] gidx,
   output logic                 any
);
   localparam int IW = idx_bits(N);

   if (N < 2) begin : g_bad_n
      $error("rr_pick: N must be at least 2");
   end

   always_comb begin
      int cand;
      gnt  = '0;
      gidx = '0;
      any  = 1'b0;
      for (int k = 1; k <= N; k++) begin
         cand = ring_step(int'(last), k, N);
         if (!any && req[cand]) begin
            any       = 1'b1;
            gnt[cand] = 1'b1;
            gidx      = IW'(cand);
         end
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("more than one grant"); // R6
   AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0) else $error("grant to non-requester"); // R6
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
   import thrd_sel_pkg::*;
#(
   parameter int NUM_THR   = 4,
   parameter int INSTR_W   = 32,
   parameter int BUF_DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_THR-1:0]           pf_push,
   input  logic [NUM_THR*INSTR_W-1:0]   pf_data,
   output logic [NUM_THR-1:0]           pf_full,
   input  logic [NUM_THR-1:0]           stall,
   input  logic [NUM_THR-1:0]           flush,
   output logic                         iss_valid,
   output logic [$clog2(NUM_THR)-1:0]   iss_tid,
   output logic [INSTR_W-1:0]           iss_instr
);
   localparam int IW = idx_bits(NUM_THR);

   if (NUM_THR < 2) begin : g_bad_thr
      $error("thread_issue_sel: NUM_THR must be at least 2");
   end
   if ((NUM_THR & (NUM_THR - 1)) != 0) begin : g_bad_thr_pow2
      $error("thread_issue_sel: NUM_THR must be a power of two");
   end

   logic [INSTR_W-1:0] head_arr [NUM_THR];
   logic [NUM_THR-1:0] q_empty, q_full, elig, gnt, pop;
   logic [IW-1:0]      last_q, gidx;
   logic               any;

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      thr_fifo #(
         .WIDTH (INSTR_W),
         .DEPTH (BUF_DEPTH)
      ) i_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (pf_push[t]),
         .din   (pf_data[t*INSTR_W +: INSTR_W]),
         .pop   (pop[t]),
         .flush (flush[t]),
         .head  (head_arr[t]),
         .empty (q_empty[t]),
         .full  (q_full[t])
      );
      assign elig[t] = !q_empty[t] && !stall[t] && !flush[t];
      assign pop[t]  = gnt[t];
   end

   rr_pick #(.N(NUM_THR)) i_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (elig),
      .last  (last_q),
      .gnt   (gnt),
      .gidx  (gidx),
      .any   (any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= IW'(NUM_THR - 1);
      else if (any) last_q <= gidx;
   end

   assign pf_full   = q_full;
   assign iss_valid = any;
   assign iss_tid   = gidx;
   assign iss_instr = head_arr[gidx];

   AST_NO_STALLED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> !stall[iss_tid]) else $error("stalled thread issued"); // R4
   AST_NO_EMPTY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> !q_empty[iss_tid]) else $error("empty thread issued"); // R5
   AST_VALID_MATCHES_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid == |(~q_empty & ~stall & ~flush)) else $error("valid disagrees with eligibility"); // R7
   AST_NO_FLUSHED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> !flush[iss_tid]) else $error("flushed thread issued"); // R9
endmodule

// File: tb/test_thread_issue_sel.sv
module test_thread_issue_sel;
   localparam int NT = 4;
   localparam int W  = 32;
   localparam int D  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NT-1:0]   pf_push = '0, stall = '0, flush = '0;
   logic [NT*W-1:0] pf_data = '0;
   logic [NT-1:0]   pf_full;
   logic            iss_valid;
   logic [1:0]      iss_tid;
   logic [W-1:0]    iss_instr;

   int n_chk = 0, n_bad = 0, cycles = 0, seq = 0;
   int q [NT][$];
   int last = NT - 1;
   bit first_after_rst = 1'b0;

   always #5 clk = ~clk;

   thread_issue_sel #(.NUM_THR(NT), .INSTR_W(W), .BUF_DEPTH(D)) i_thread_issue_sel (
      .clk(clk), .rst_n(rst_n), .pf_push(pf_push), .pf_data(pf_data), .pf_full(pf_full),
      .stall(stall), .flush(flush), .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_instr(iss_instr)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // Reference model: compare at the falling edge, then advance as the rising edge would.
   always @(negedge clk) begin
      cycles++;
      if (!rst_n) begin
         for (int t = 0; t < NT; t++) q[t].delete();
         last = NT - 1;
         first_after_rst = 1'b1;
         chk("R1 valid in reset", iss_valid, 0);
         chk("R1 full in reset", pf_full, 0);
      end else begin
         int pick;
         bit [NT-1:0] ef;
         pick = -1;
         for (int k = 1; k <= NT; k++) begin
            int c;
            c = (last + k) % NT;
            if (pick < 0 && q[c].size() > 0 && !stall[c] && !flush[c]) pick = c;
         end
         for (int t = 0; t < NT; t++) ef[t] = (q[t].size() == D);
         if (first_after_rst) begin
            chk("R1 valid after reset", iss_valid, 0);
            chk("R1 full after reset", pf_full, 0);
            first_after_rst = 1'b0;
         end
         chk("R7 valid", iss_valid, pick >= 0);
         chk("R3 full flags", pf_full, ef);
         if (iss_valid) begin
            chk("R4 stalled thread selected", stall[iss_tid], 0);
            chk("R5 empty thread selected", q[iss_tid].size() == 0, 0);
            chk("R9 flushed thread selected", flush[iss_tid], 0);
         end
         if (pick >= 0) begin
            chk("R6 selected thread", iss_tid, pick);
            chk("R2 R8 instruction word", iss_instr, q[pick][0]);
         end
         for (int t = 0; t < NT; t++) begin
            if (flush[t]) q[t].delete();
            else begin
               bit was_full;
               was_full = (q[t].size() == D);
               if (pick == t) void'(q[t].pop_front());
               if (pf_push[t] && !was_full) q[t].push_back(pf_data[t*W +: W]);
            end
         end
         if (pick >= 0) last = pick;
      end
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic step(input logic [NT-1:0] psh, input logic [NT-1:0] stl, input logic [NT-1:0] fl);
      @(posedge clk);
      #1;
      pf_push = psh;
      stall   = stl;
      flush   = fl;
      for (int t = 0; t < NT; t++) begin
         pf_data[t*W +: W] = (t << 24) | seq;
         seq++;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R2 R8: one thread alone, order preserved
      for (int i = 0; i < 3; i++) step(4'b0001, 4'b0000, 4'b0000);
      repeat (5) step(4'b0000, 4'b0000, 4'b0000);
      // R3: fill thread 1 while stalled, fifth push dropped; R4 held off
      for (int i = 0; i < 5; i++) step(4'b0010, 4'b0010, 4'b0000);
      repeat (2) step(4'b0010, 4'b0010, 4'b0000);
      repeat (6) step(4'b0000, 4'b0000, 4'b0000);
      // R3: push into a full queue while it issues
      for (int i = 0; i < 4; i++) step(4'b0010, 4'b0010, 4'b0000);
      step(4'b0010, 4'b0000, 4'b0000);
      repeat (6) step(4'b0000, 4'b0000, 4'b0000);
      // R6: all threads loaded, rotating issue
      repeat (2) step(4'b1111, 4'b1111, 4'b0000);
      repeat (10) step(4'b0000, 4'b0000, 4'b0000);
      // R4: thread 2 stalled among busy threads
      repeat (3) step(4'b1111, 4'b0100, 4'b0000);
      repeat (6) step(4'b0000, 4'b0100, 4'b0000);
      repeat (4) step(4'b0000, 4'b0000, 4'b0000);
      // R9: flush thread 3 with a simultaneous push
      repeat (3) step(4'b1000, 4'b1000, 4'b0000);
      step(4'b1000, 4'b0000, 4'b1000);
      repeat (4) step(4'b0000, 4'b0000, 4'b0000);
      // R5 R7: everything empty gives bubbles
      repeat (3) step(4'b0000, 4'b0000, 4'b0000);
      // mixed traffic
      for (int i = 0; i < 2000; i++) begin
         logic [NT-1:0] p, s, f;
         for (int t = 0; t < NT; t++) begin
            p[t] = ($urandom % 2) == 0;
            s[t] = ($urandom % 4) == 0;
            f[t] = ($urandom % 40) == 0;
         end
         step(p, s, f);
      end
      repeat (12) step(4'b0000, 4'b0000, 4'b0000);
      @(posedge clk);
      #2;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule